// File: doc/BRIEF.md
# Dual-Clock Registered Embedded RAM

This block is a 2048-bit simple dual-port memory. It has one write port and one read port, and each port runs on its own clock. The shape of the memory is fixed when the design is elaborated: the width can be 16, 8, 4, 2 or 1 bit, and the depth is 2048 divided by that width. The address width follows from the depth.

Every input on each side passes through a register before it touches the array. On the write side, data, address and the write request are captured on the write clock. The stored write request then produces the strobe that writes the array on the following write-clock edge. On the read side, the address and the read request are captured on the read clock. On the next read-clock edge the array word is loaded into an output register, and that register drives the output port.

Each side has its own clock enable and its own asynchronous clear. A clear on one side has no effect on the other side, and it never touches the stored words. The block is meant for designs where a producer and a consumer run at unrelated frequencies and share a small buffer.

Top module: `dcram_2clk`

## Requirements
- R1: The parameters DEPTH and DATA_W must form one of the pairs 128x16, 256x8, 512x4, 1024x2 or 2048x1. Any other pair stops elaboration. The address ports are clog2(DEPTH) bits wide, and address 0 and address DEPTH-1 hold separate words. The default is 256x8 with 8-bit addresses.
- R2: Address, data and request are captured at one write-clock edge when wr_ce is 1 and wr_en is 1. The array word at that address takes the data at the next write-clock edge at which wr_ce is 1.
- R3: rd_addr and rd_en=1 are captured at one read-clock edge when rd_ce is 1. rd_data shows the word at that address after the next read-clock edge at which rd_ce is 1. It does not show it after the first edge.
- R4: If rd_en was 0 at the capturing edge, rd_data keeps its value through the edge that follows.
- R5: While rd_ce is 0, the read side freezes. rd_data holds its value, and the captured address and request hold theirs.
- R6: While wr_ce is 0, the write side freezes. Nothing is captured and nothing is written, and a captured request stays pending until an edge at which wr_ce is 1.
- R7: rd_clr=1 forces rd_data to 0 at once, without waiting for a clock edge. It also discards the captured read request. It leaves the stored words unchanged.
- R8: wr_clr=1 discards a captured write request at once, so that request never writes the array. It leaves the stored words and the read side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_clr | input | 1 | Asynchronous clear of the write-side registers, active high |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read clock |
| rd_clr | input | 1 | Asynchronous clear of the read-side registers, active high |
| rd_ce | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench first checks the two-edge read latency: it confirms that the old word is still present one edge after a new read is requested. A design with only one read register would show the new word one edge early. It then toggles the two clock enables while reads and writes are in flight. A design that gates only the array write, or only the output load, would capture addresses during a frozen cycle or would lose a pending write. It also clears each side in the middle of an operation. A write that is already captured must then vanish, rd_data must drop to zero before any clock edge, and every stored word must read back unchanged. A design whose clear touches the array, or that leaves a captured write in place, would fail these checks.

// File: rtl/dcram_pkg.sv
package dcram_pkg;

    localparam int TOTAL_BITS = 2048;

    // True only for the five supported word widths.
    function automatic bit width_supported(int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    // The depth and width must both be supported and must multiply to the full size.
    function automatic bit shape_ok(int depth, int w);
        return width_supported(w) && (depth * w == TOTAL_BITS);
    endfunction

endpackage

// File: rtl/dcram_wr_port.sv
module dcram_wr_port #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          wr_clk,
    input  logic          wr_clr,
    input  logic          wr_ce,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_cmd_t;

    wr_cmd_t cmd_q;

    always_ff @(posedge wr_clk or posedge wr_clr) begin
        if (wr_clr) begin
            cmd_q <= '0;
        end else if (wr_ce) begin
            cmd_q <= '{en: wr_en, addr: wr_addr, data: wr_data};
        end
    end

    // The array is written by this strobe, which comes from the captured request.
    assign mem_we    = cmd_q.en & wr_ce;
    assign mem_waddr = cmd_q.addr;
    assign mem_wdata = cmd_q.data;

    assert_wr_capture_R2: assert property (@(posedge wr_clk) disable iff (wr_clr)
        wr_ce |=> (cmd_q.en == $past(wr_en)) &&
                  (!$past(wr_en) || (cmd_q.addr == $past(wr_addr) && cmd_q.data == $past(wr_data))));

    assert_wr_freeze_R6: assert property (@(posedge wr_clk) disable iff (wr_clr)
        !wr_ce |=> $stable(cmd_q));

    assert_wr_nostrobe_R6: assert property (@(posedge wr_clk) disable iff (wr_clr)
        !wr_ce |-> !mem_we);

    always @(posedge wr_clk) begin
        if (wr_clr) begin
            assert_wr_clear_R8: assert (cmd_q.en == 1'b0);
        end
    end
endmodule

// File: rtl/dcram_array.sv
module dcram_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // The array has no reset; a clear on either side never touches it.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcram_rd_port.sv
module dcram_rd_port #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          rd_clk,
    input  logic          rd_clr,
    input  logic          rd_ce,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } rd_cmd_t;

    rd_cmd_t       cmd_q;
    logic [DW-1:0] dout_q;

    always_ff @(posedge rd_clk or posedge rd_clr) begin
        if (rd_clr) begin
            cmd_q  <= '0;
            dout_q <= '0;
        end else if (rd_ce) begin
            if (cmd_q.en) begin
                dout_q <= mem_rdata;
            end
            cmd_q <= '{en: rd_en, addr: rd_addr};
        end
    end

    assign mem_raddr = cmd_q.addr;
    assign rd_data   = dout_q;

    assert_rd_load_R3: assert property (@(posedge rd_clk) disable iff (rd_clr)
        (rd_ce && cmd_q.en) |=> (rd_data === $past(mem_rdata)));

    assert_rd_gate_R4: assert property (@(posedge rd_clk) disable iff (rd_clr)
        !cmd_q.en |=> $stable(rd_data));

    assert_rd_freeze_R5: assert property (@(posedge rd_clk) disable iff (rd_clr)
        !rd_ce |=> $stable(rd_data) && $stable(cmd_q));

    always @(posedge rd_clk) begin
        if (rd_clr) begin
            assert_rd_clear_R7: assert (rd_data == '0 && cmd_q.en == 1'b0);
        end
    end
endmodule

// File: rtl/dcram_2clk.sv
module dcram_2clk
    import dcram_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int DATA_W = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_clr,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_clr,
    input  logic              rd_ce,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    // R1: only the five supported shapes may be elaborated.
    generate
        if (!shape_ok(DEPTH, DATA_W)) begin : g_bad_shape
            $error("dcram_2clk: unsupported shape %0d x %0d", DEPTH, DATA_W);
        end
    endgenerate

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [AW-1:0]     mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    dcram_wr_port #(.AW(AW), .DW(DATA_W)) u_wr (
        .wr_clk   (wr_clk),
        .wr_clr   (wr_clr),
        .wr_ce    (wr_ce),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    dcram_array #(.DEPTH(DEPTH), .AW(AW), .DW(DATA_W)) u_mem (
        .wr_clk(wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcram_rd_port #(.AW(AW), .DW(DATA_W)) u_rd (
        .rd_clk   (rd_clk),
        .rd_clr   (rd_clr),
        .rd_ce    (rd_ce),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/test_dcram_2clk.sv
module test_dcram_2clk;
    localparam int DEPTH = 256;
    localparam int DW    = 8;
    localparam int AW    = 8;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_clr = 1'b1, rd_clr = 1'b1;
    logic          wr_ce = 1'b0, wr_en = 1'b0, rd_ce = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int    total = 0, bad = 0;
    bit    done = 1'b0, cmp_on = 1'b0;
    string phase = "R7";

    always #5 wr_clk = ~wr_clk;   // 100 MHz write clock
    always #7 rd_clk = ~rd_clk;   // unrelated read clock

    dcram_2clk #(.DEPTH(DEPTH), .DATA_W(DW)) i_dcram_2clk (
        .wr_clk(wr_clk), .wr_clr(wr_clr), .wr_ce(wr_ce), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_clr(rd_clr), .rd_ce(rd_ce), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Behavioural reference: stored words plus pending request per side.
    int ref_mem [int];
    int w_pend_en, w_pend_addr, w_pend_data;
    int r_pend_en, r_pend_addr, r_out;

    always @(posedge wr_clk or posedge wr_clr) begin
        if (wr_clr) begin
            w_pend_en <= 0;
        end else if (wr_ce) begin
            if (w_pend_en != 0) ref_mem[w_pend_addr] = w_pend_data;
            w_pend_en   <= int'(wr_en);
            w_pend_addr <= int'(wr_addr);
            w_pend_data <= int'(wr_data);
        end
    end

    always @(posedge rd_clk or posedge rd_clr) begin
        if (rd_clr) begin
            r_pend_en <= 0;
            r_out     <= 0;
        end else if (rd_ce) begin
            if (r_pend_en != 0) r_out <= ref_mem[r_pend_addr];
            r_pend_en   <= int'(rd_en);
            r_pend_addr <= int'(rd_addr);
        end
    end

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 29 + 7) % 256);
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the reference on every read clock.
    always @(negedge rd_clk) begin
        if (cmp_on && !rd_clr) chk(phase, rd_data, DW'(r_out));
    end

    task automatic wr_cyc(bit en, int a, logic [DW-1:0] d, bit ce);
        @(negedge wr_clk);
        wr_en = en; wr_addr = AW'(a); wr_data = d; wr_ce = ce;
    endtask

    task automatic rd_cyc(bit en, int a, bit ce);
        @(negedge rd_clk);
        rd_en = en; rd_addr = AW'(a); rd_ce = ce;
    endtask

    task automatic wr_flush();
        for (int i = 0; i < 3; i++) wr_cyc(1'b0, 0, '0, 1'b1);
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic rd_idle();
        for (int i = 0; i < 3; i++) rd_cyc(1'b0, 0, 1'b1);
    endtask

    initial begin
        #30;
        chk("R7 reset state", rd_data, '0);
        #3 wr_clr = 1'b0; rd_clr = 1'b0;
        cmp_on = 1'b1;

        phase = "R2 fill";
        for (int a = 0; a < DEPTH; a++) wr_cyc(1'b1, a, pat(a), 1'b1);
        wr_flush();

        phase = "R3 sweep";
        for (int a = 0; a < DEPTH; a++) rd_cyc(1'b1, a, 1'b1);
        rd_idle();

        phase = "R1 ends";
        rd_cyc(1'b1, DEPTH - 1, 1'b1); rd_idle();
        chk("R1 top address", rd_data, pat(DEPTH - 1));
        rd_cyc(1'b1, 0, 1'b1); rd_idle();
        chk("R1 address zero", rd_data, pat(0));

        phase = "R3 latency";
        rd_cyc(1'b1, 20, 1'b1); rd_idle();
        rd_cyc(1'b1, 10, 1'b1);
        @(negedge rd_clk);
        chk("R3 one edge later", rd_data, pat(20));
        rd_en = 1'b0;
        @(negedge rd_clk);
        chk("R3 two edges later", rd_data, pat(10));

        phase = "R4 gated";
        for (int a = 0; a < 64; a++) rd_cyc((a % 3) != 0, a * 4 + 1, 1'b1);
        rd_idle();

        phase = "R5 rd_ce";
        for (int a = 0; a < 64; a++) rd_cyc(1'b1, 255 - a, (a % 4) != 1);
        rd_idle();

        phase = "R6 wr_ce";
        for (int a = 0; a < 32; a++) wr_cyc(1'b1, a, ~pat(a), a[0]);
        wr_flush();
        for (int i = 0; i < 4; i++) wr_cyc(1'b1, 100, 8'hAA, 1'b0);
        wr_cyc(1'b0, 0, '0, 1'b1);
        wr_flush();
        for (int a = 0; a < 32; a++) rd_cyc(1'b1, a, 1'b1);
        rd_cyc(1'b1, 100, 1'b1); rd_idle();
        chk("R6 frozen write ignored", rd_data, pat(100));

        phase = "R7 clear";
        for (int a = 40; a < 48; a++) rd_cyc(1'b1, a, 1'b1);
        #2 rd_clr = 1'b1;
        #1 chk("R7 async zero", rd_data, '0);
        @(posedge rd_clk); #2 rd_clr = 1'b0;
        for (int a = 40; a < 56; a++) rd_cyc(1'b1, a, 1'b1);
        rd_idle();
        chk("R7 array intact", rd_data, pat(55));

        phase = "R8 clear";
        wr_cyc(1'b1, 200, 8'h5C, 1'b1);
        @(posedge wr_clk);
        #2 wr_en = 1'b0; wr_clr = 1'b1;
        @(posedge wr_clk); #2 wr_clr = 1'b0;
        wr_flush();
        rd_cyc(1'b1, 200, 1'b1); rd_idle();
        chk("R8 pending write dropped", rd_data, pat(200));
        rd_cyc(1'b1, 201, 1'b1); rd_idle();
        chk("R8 array intact", rd_data, pat(201));

        cmp_on = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog in phase %s: running=1 expected=0", phase);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule